// File: doc/BRIEF.md
# Burst Word Address Generator with Selectable Order

This block produces the word address for a synchronous burst memory. When either of two address strobes is sampled high, it captures the full external address as the burst base. On later cycles it generates the two least significant address bits internally, stepping them once for each cycle in which the advance input is high. The upper address bits stay at the captured value for the whole burst.

A burst covers four words. The step sequence is either linear (wrapping add) or interleaved (XOR with the step count), and one order input picks between them. The order input encodes interleaved as 0, so an input that is tied low, or left at its inactive level, gives interleaved order. Bursting is optional. A strobe may arrive on every cycle, and each one loads a new address that appears at the output one clock later.

The generated address is a registered value. It changes only on a rising clock edge and never combinationally from the inputs.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `addr_o` is all zeros and `burst_active_o` is 0.
- R2: On a rising edge where `strobe_cpu_i` or `strobe_ctl_i` is 1, the block loads `addr_i`. From the next cycle `addr_o` equals that address exactly and `burst_active_o` is 1. This holds on back-to-back cycles with no idle cycle between loads.
- R3: While `burst_active_o` is 1 and no strobe is high, each rising edge with `adv_i` = 1 moves the burst forward by one word.
- R4: With `order_lin_i` = 1 at the start of the burst (linear), the low two bits after n advances are (base[1:0] + n) mod 4.
- R5: With `order_lin_i` = 0 at the start of the burst (interleaved, the tied-low default), the low two bits after n advances are base[1:0] XOR n.
- R6: A rising edge with `adv_i` = 0 and no strobe leaves `addr_o` and `burst_active_o` unchanged.
- R7: `addr_o[ADDR_W-1:2]` changes only on an edge with a strobe high.
- R8: A strobe during an active burst restarts the burst from the new base address at step 0.
- R9: The order is sampled only on a strobe edge. Changing `order_lin_i` during a burst has no effect on that burst's sequence.
- R10: An advance while on the fourth word (step 3) ends the burst. `burst_active_o` goes to 0 and `addr_o` keeps the fourth word. Further advances without a strobe leave `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu_i | input | 1 | Processor-side address strobe, starts a burst |
| strobe_ctl_i | input | 1 | Controller-side address strobe, starts a burst |
| adv_i | input | 1 | Advance to the next burst word |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | External address captured on a strobe |
| addr_o | output | ADDR_W | Current word address |
| burst_active_o | output | 1 | High from a strobe until the burst completes |

## Verification
A wrong step count or a wrong stored order shows on `addr_o[1:0]` in the first cycle after the faulty advance. Every advance inside a burst must change the low bits, so the error cannot stay hidden. A corrupted base register shows on the upper bits on the very next cycle, and the check that those bits are stable without a strobe catches it at once. A wrong active flag shows either as an advance that should have moved the address but did not, or as one that moved it when it should not have. Both are visible one clock after the advance.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic {
        ORD_INTLV  = 1'b0,
        ORD_LINEAR = 1'b1
    } burst_order_e;

    localparam int unsigned STEP_W = 2;
endpackage

// File: rtl/bag_step_ctr.sv
module bag_step_ctr
    import bag_pkg::*;
#(
    parameter int unsigned SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    output logic [SW-1:0] step_o,
    output logic          active_o
);
    localparam logic [SW-1:0] LAST = {SW{1'b1}};

    typedef struct packed {
        logic [SW-1:0] step;
        logic          active;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.step   = '0;
            st_d.active = 1'b1;
        end else if (st_q.active && adv_i) begin
            if (st_q.step == LAST) begin
                st_d.active = 1'b0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o   = st_q.step;
    assign active_o = st_q.active;
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg
    import bag_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [AW-1:0] addr_i,
    input  burst_order_e order_i,
    output logic [AW-1:0] base_o,
    output burst_order_e order_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        burst_order_e  order;
    } base_t;

    base_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base  = addr_i;
            st_d.order = order_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{base: '0, order: ORD_INTLV};
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.base;
    assign order_o = st_q.order;
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import bag_pkg::*;
#(
    parameter int unsigned SW = STEP_W
) (
    input  logic [SW-1:0] base_lo_i,
    input  logic [SW-1:0] step_i,
    input  burst_order_e  order_i,
    output logic [SW-1:0] lo_o
);
    logic [SW-1:0] lin_lo;
    logic [SW-1:0] xor_lo;

    always_comb begin
        lin_lo = base_lo_i + step_i;
        xor_lo = base_lo_i ^ step_i;
        case (order_i)
            ORD_LINEAR: lo_o = lin_lo;
            default:    lo_o = xor_lo;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_cpu_i,
    input  logic              strobe_ctl_i,
    input  logic              adv_i,
    input  logic              order_lin_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              burst_active_o
);
    localparam int unsigned HI_W = ADDR_W - STEP_W;

    logic              load;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] base;
    burst_order_e      order_q;
    burst_order_e      order_in;
    logic [STEP_W-1:0] lo;

    assign load     = strobe_cpu_i | strobe_ctl_i;
    assign order_in = order_lin_i ? ORD_LINEAR : ORD_INTLV;

    bag_base_reg #(.AW(ADDR_W)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .addr_i  (addr_i),
        .order_i (order_in),
        .base_o  (base),
        .order_o (order_q)
    );

    bag_step_ctr #(.SW(STEP_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .adv_i    (adv_i),
        .step_o   (step),
        .active_o (burst_active_o)
    );

    bag_order_map #(.SW(STEP_W)) map_i (
        .base_lo_i (base[STEP_W-1:0]),
        .step_i    (step),
        .order_i   (order_q),
        .lo_o      (lo)
    );

    assign addr_o = {base[ADDR_W-1 -: HI_W], lo};
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_cpu_i,
    input logic              strobe_ctl_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              burst_active_o
);
    logic any_strobe;
    assign any_strobe = strobe_cpu_i | strobe_ctl_i;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && !burst_active_o));

    a_r2_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (addr_o == $past(addr_i) && burst_active_o));

    a_r3_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active_o && adv_i && !any_strobe)
        |=> (addr_o[1:0] != $past(addr_o[1:0]) || !burst_active_o));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !any_strobe) |=> ($stable(addr_o) && $stable(burst_active_o)));

    a_r7_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(addr_o[ADDR_W-1:2]));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active_o && !any_strobe) |=> ($stable(addr_o) && !burst_active_o));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_cpu_i   (strobe_cpu_i),
    .strobe_ctl_i   (strobe_ctl_i),
    .adv_i          (adv_i),
    .addr_i         (addr_i),
    .addr_o         (addr_o),
    .burst_active_o (burst_active_o)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
    localparam int unsigned AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_cpu = 1'b0, s_ctl = 1'b0, adv = 1'b0, lin = 1'b0;
    logic [AW-1:0] a_in = '0;
    logic [AW-1:0] a_out;
    logic          act;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_cpu_i   (s_cpu),
        .strobe_ctl_i   (s_ctl),
        .adv_i          (adv),
        .order_lin_i    (lin),
        .addr_i         (a_in),
        .addr_o         (a_out),
        .burst_active_o (act)
    );

    // Vector: order (1 linear), base low bits, expected low bits for steps 0..3
    typedef struct packed {
        logic       ord;
        logic [1:0] b;
        logic [1:0] e0, e1, e2, e3;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
        '{1'b0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
        '{1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
        '{1'b0, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0},
        '{1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
        '{1'b1, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
        '{1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
        '{1'b1, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2}
    };

    task automatic chk(input string tag, input logic [AW:0] act_v, input logic [AW:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    // Drive inputs, wait one rising edge, settle 1 ns
    task automatic step(input logic sc, input logic sl, input logic ad,
                        input logic ln, input logic [AW-1:0] a);
        s_cpu = sc; s_ctl = sl; adv = ad; lin = ln; a_in = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] hi;
        logic [1:0]    ex [4];

        // R1: during and after reset
        repeat (3) step(0, 0, 1, 0, 20'hFFFFF);
        chk("R1 in reset", {act, a_out}, '0);
        rst_n = 1'b1;
        step(0, 0, 1, 0, 20'h12345);
        chk("R1 after reset", {act, a_out}, '0);

        // R3 R4 R5 R7: table of both orders and all start offsets
        for (int v = 0; v < 8; v++) begin
            hi    = AW'(20'h5A3C1 + v * 20'h01234) & ~20'h3;
            ex[0] = VECS[v].e0; ex[1] = VECS[v].e1;
            ex[2] = VECS[v].e2; ex[3] = VECS[v].e3;
            step(v[0], ~v[0], 0, VECS[v].ord, hi | 20'(VECS[v].b));
            for (int n = 0; n < 4; n++) begin
                chk(VECS[v].ord ? "R4 linear seq" : "R5 interleaved seq",
                    {act, a_out}, {1'b1, hi | 20'(ex[n])});
                if (n < 3) step(0, 0, 1, VECS[v].ord, 20'h0);
            end
        end

        // R10: advance on fourth word ends burst, address kept
        step(0, 0, 1, 1, 20'h0);
        chk("R10 burst end", {act, a_out}, {1'b0, 20'h5A3C1 + 7 * 20'h01234 & ~20'h3 | 20'h2});
        step(0, 0, 1, 0, 20'hFFFFF);
        chk("R10 adv ignored when idle", {act, a_out}, {1'b0, 20'h5A3C1 + 7 * 20'h01234 & ~20'h3 | 20'h2});

        // R2: back-to-back loads from alternating strobes
        step(1, 0, 0, 0, 20'hABCDE);
        chk("R2 load cpu strobe", {act, a_out}, {1'b1, 20'hABCDE});
        step(0, 1, 1, 1, 20'h13579);
        chk("R2 load ctl strobe next cycle", {act, a_out}, {1'b1, 20'h13579});
        step(1, 1, 0, 0, 20'h02468);
        chk("R2 both strobes", {act, a_out}, {1'b1, 20'h02468});

        // R6: hold with adv low
        step(0, 0, 1, 0, 20'h0);
        chk("R6 pre-hold advance", {act, a_out}, {1'b1, 20'h02469});
        step(0, 0, 0, 1, 20'hFFFFF);
        step(0, 0, 0, 0, 20'h77777);
        chk("R6 hold", {act, a_out}, {1'b1, 20'h02469});

        // R8: strobe mid-burst restarts at new base
        step(0, 1, 1, 1, 20'h40001);
        chk("R8 restart", {act, a_out}, {1'b1, 20'h40001});
        step(0, 0, 1, 0, 20'h0);
        chk("R8 first advance after restart (linear)", {act, a_out}, {1'b1, 20'h40002});

        // R9: order change mid-burst ignored (burst started linear)
        step(0, 0, 1, 0, 20'h0);
        chk("R9 order held", {act, a_out}, {1'b1, 20'h40003});
        step(0, 0, 1, 0, 20'h0);
        chk("R9 order held wrap", {act, a_out}, {1'b1, 20'h40000});

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule